// File: doc/BRIEF.md
# Rotate-Through-Flag Shift Unit

This block is the shift and rotate stage of a small processor's execute path. Each accepted operation reads a destination word, a second source word, a shift count, a 3-bit operation code, the incoming carry flag and the incoming extend flag. One cycle later it presents the shifted word, the updated carry and extend flags, and a zero indication.

There are eight operations in four groups. Two are plain rotates. Two rotate the word together with a single flag bit, so the word and the flag act as one register that is one bit wider. Two are logical shifts that fill with zeros. Two are funnel shifts that take their fill bits from the second source word.

The parameter `USE_EXTEND` selects which flag acts as the extra rotate bit. With `USE_EXTEND=0` it is the carry flag. With `USE_EXTEND=1` it is a separate extend flag, and every nonzero shift or rotate then writes the bit shifted out into both the carry flag and the extend flag. The unit never clears a flag on its own. To shift a zero in through the flag path, the flag must already be clear when the operation is issued.

Top module: `rcx_shift_unit`

## Requirements
- R1: Operation code 2 (rotate left through flag) by k gives an (N+1)-bit left rotation of {flag, word}. The new word is the low N bits of that rotation and the new flag is its top bit.
- R2: Operation code 3 (rotate right through flag) by k gives the matching (N+1)-bit right rotation. The old flag enters the top bit of the word, and the last bit to leave bit 0 becomes the new flag.
- R3: A rotate left through flag by 1 gives exactly the same {flag, word} as word + word + flag.
- R4: For the through-flag rotates, the count is taken modulo N+1. A count that reduces to 0 leaves the word and both flags unchanged.
- R5: Operation codes 0 and 1 rotate the word left and right by the low log2(N) bits of the count. The carry flag takes the last bit that wrapped around.
- R6: Operation codes 4 and 5 shift the word left and right with zero fill, and the carry flag takes the last bit shifted out. A through-flag rotate issued with the flag set shifts in a 1; the unit does not clear the flag.
- R7: Operation code 6 shifts the destination left and fills the vacated low bits from the top bits of the source word. Operation code 7 shifts the destination right and fills the vacated high bits from the bottom bits of the source word.
- R8: For operation codes 0, 1 and 4 to 7, the count is masked to its low log2(N) bits. A masked count of 0 returns the destination word unchanged and leaves both flags unchanged.
- R9: With USE_EXTEND=1, the extend input is the extra rotate bit. Every nonzero shift writes the bit shifted out into both carry_out and ext_out. With USE_EXTEND=0, ext_out equals the extend input of the operation.
- R10: zero_out is 1 exactly when the produced N-bit word is all zeros.
- R11: Results and out_valid appear on the clock edge after in_valid is sampled high. While in_valid is low, result and the flags hold and out_valid is 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| op | input | 3 | Operation code 0..7 (see R1 to R8) |
| dst_a | input | N | Word to be shifted |
| src_b | input | N | Fill source for funnel shifts |
| count | input | CNT_W | Shift count, log2(N)+1 bits |
| carry_in | input | 1 | Current carry flag |
| ext_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result registers updated last edge |
| result | output | N | Shifted word |
| carry_out | output | 1 | Updated carry flag |
| ext_out | output | 1 | Updated extend flag |
| zero_out | output | 1 | Result is all zeros |

## Verification
The assertions assume that `count` never exceeds 2N-1, which the port width guarantees. They also assume that operation inputs are steady around the clock edge on which `in_valid` is sampled. The stimulus changes inputs only on falling edges. It covers every operation code with counts from 0 up to the largest value the port can carry, which includes the wrap values N+1 and above for the through-flag rotates. It drives both flag states so that a set flag is seen travelling into the word.

// File: rtl/rcx_pkg.sv
package rcx_pkg;
   typedef enum logic [2:0] {
      OP_ROL  = 3'd0,
      OP_ROR  = 3'd1,
      OP_RCL  = 3'd2,
      OP_RCR  = 3'd3,
      OP_SHL  = 3'd4,
      OP_SHR  = 3'd5,
      OP_SHLD = 3'd6,
      OP_SHRD = 3'd7
   } rcx_op_e;
endpackage

// File: rtl/rcx_funnel.sv
// Funnel shifter: dst shifted by amt, vacated bits taken from fill.
module rcx_funnel #(
   parameter int N  = 8,
   parameter int SW = 3
) (
   input  logic [N-1:0]  dst,
   input  logic [N-1:0]  fill,
   input  logic [SW-1:0] amt,
   input  logic          go_left,
   output logic [N-1:0]  res,
   output logic          bit_out
);
   localparam int FW = 2*N + 1;

   logic [FW-1:0] left_t;
   logic [FW-1:0] right_t;

   assign left_t  = {1'b0, dst, fill} << amt;
   assign right_t = {fill, dst, 1'b0} >> amt;

   assign res     = go_left ? left_t[2*N-1:N] : right_t[N:1];
   assign bit_out = go_left ? left_t[2*N]     : right_t[0];
endmodule

// File: rtl/rcx_thru_rot.sv
// (N+1)-bit rotation of {flag, word}; count reduced modulo N+1.
module rcx_thru_rot #(
   parameter int N     = 8,
   parameter int CNT_W = 4
) (
   input  logic [N-1:0]     dst,
   input  logic             fin,
   input  logic [CNT_W-1:0] cnt,
   input  logic             go_left,
   output logic [N-1:0]     res,
   output logic             fout,
   output logic             active
);
   localparam int RW = N + 1;
   localparam logic [CNT_W-1:0] RW_C = CNT_W'(RW);

   logic [CNT_W-1:0] k;
   logic [CNT_W-1:0] k_inv;
   logic [RW-1:0]    ext_word;
   logic [RW-1:0]    rot_l;
   logic [RW-1:0]    rot_r;
   logic [RW-1:0]    rot;

   // count never exceeds 2N-1 < 2(N+1), so one subtraction suffices
   assign k        = (cnt >= RW_C) ? (cnt - RW_C) : cnt;
   assign k_inv    = RW_C - k;
   assign ext_word = {fin, dst};
   assign rot_l    = (ext_word << k) | (ext_word >> k_inv);
   assign rot_r    = (ext_word >> k) | (ext_word << k_inv);
   assign rot      = go_left ? rot_l : rot_r;

   assign res    = rot[N-1:0];
   assign fout   = rot[N];
   assign active = (k != '0);
endmodule

// File: rtl/rcx_shift_unit.sv
module rcx_shift_unit
   import rcx_pkg::*;
#(
   parameter int N          = 8,
   parameter bit USE_EXTEND = 1'b0,
   parameter int CNT_W      = $clog2(N) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       op,
   input  logic [N-1:0]     dst_a,
   input  logic [N-1:0]     src_b,
   input  logic [CNT_W-1:0] count,
   input  logic             carry_in,
   input  logic             ext_in,
   output logic             out_valid,
   output logic [N-1:0]     result,
   output logic             carry_out,
   output logic             ext_out,
   output logic             zero_out
);
   localparam int SW = $clog2(N);

   generate
      if (N < 2 || (1 << SW) != N) begin : g_bad_width
         $fatal(1, "rcx_shift_unit: N must be a power of two >= 2");
      end
      if (CNT_W != SW + 1) begin : g_bad_cnt
         $fatal(1, "rcx_shift_unit: CNT_W must equal log2(N)+1");
      end
   endgenerate

   rcx_op_e        opc;
   logic           is_rc;
   logic           go_left;
   logic [SW-1:0]  amt;
   logic           rot_in;
   logic [N-1:0]   fill;
   logic [N-1:0]   fun_res;
   logic           fun_bit;
   logic [N-1:0]   rc_res;
   logic           rc_bit;
   logic           rc_active;
   logic           moved;
   logic           out_bit;
   logic [N-1:0]   nxt_res;
   logic           nxt_carry;
   logic           nxt_ext;

   assign opc     = rcx_op_e'(op);
   assign is_rc   = (opc == OP_RCL) || (opc == OP_RCR);
   assign go_left = ~op[0];
   assign amt     = count[SW-1:0];

   // choice of the extra rotate bit
   generate
      if (USE_EXTEND) begin : g_ext_bit
         assign rot_in  = ext_in;
         assign nxt_ext = moved ? out_bit : ext_in;
      end else begin : g_carry_bit
         assign rot_in  = carry_in;
         assign nxt_ext = ext_in;
      end
   endgenerate

   always_comb begin
      unique case (opc)
         OP_ROL, OP_ROR:   fill = dst_a;
         OP_SHLD, OP_SHRD: fill = src_b;
         default:          fill = '0;
      endcase
   end

   rcx_funnel #(.N(N), .SW(SW)) u_funnel (
      .dst     (dst_a),
      .fill    (fill),
      .amt     (amt),
      .go_left (go_left),
      .res     (fun_res),
      .bit_out (fun_bit)
   );

   rcx_thru_rot #(.N(N), .CNT_W(CNT_W)) u_thru (
      .dst     (dst_a),
      .fin     (rot_in),
      .cnt     (count),
      .go_left (go_left),
      .res     (rc_res),
      .fout    (rc_bit),
      .active  (rc_active)
   );

   assign moved     = is_rc ? rc_active : (amt != '0);
   assign out_bit   = is_rc ? rc_bit : fun_bit;
   assign nxt_res   = is_rc ? rc_res : fun_res;
   assign nxt_carry = moved ? out_bit : carry_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         carry_out <= 1'b0;
         ext_out   <= 1'b0;
         zero_out  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            carry_out <= nxt_carry;
            ext_out   <= nxt_ext;
            zero_out  <= (nxt_res == '0);
         end
      end
   end

   // ---------------- assertions ----------------
   p_adc_equiv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc == OP_RCL && count == CNT_W'(1)) |=>
      ({carry_out, result} ==
       $past({1'b0, dst_a} + {1'b0, dst_a} + (N+1)'(rot_in))));

   p_rcr_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc == OP_RCR && count == CNT_W'(1)) |=>
      (result == {$past(rot_in), $past(dst_a[N-1:1])}) &&
      (carry_out == $past(dst_a[0])));

   p_shl_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc == OP_SHL && amt != '0) |=> (result[0] == 1'b0));

   p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_rc && amt == '0) |=>
      (result == $past(dst_a)) && (carry_out == $past(carry_in)) &&
      (ext_out == $past(ext_in)));

   p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (zero_out == (result == '0)));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(result) && $stable(carry_out) &&
      $stable(ext_out));
endmodule

// File: tb/rcx_shift_unit_tb.sv
module rcx_shift_unit_tb;
   localparam int N      = 8;
   localparam int CNT_W  = 4;
   localparam int CLK_NS = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [2:0]       op = '0;
   logic [N-1:0]     dst_a = '0;
   logic [N-1:0]     src_b = '0;
   logic [CNT_W-1:0] count = '0;
   logic             carry_in = 1'b0;
   logic             ext_in = 1'b0;

   logic             ov_c, co_c, xo_c, zo_c;
   logic [N-1:0]     res_c;
   logic             ov_x, co_x, xo_x, zo_x;
   logic [N-1:0]     res_x;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   rcx_shift_unit #(.N(N), .USE_EXTEND(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .dst_a(dst_a), .src_b(src_b), .count(count),
      .carry_in(carry_in), .ext_in(ext_in),
      .out_valid(ov_c), .result(res_c), .carry_out(co_c),
      .ext_out(xo_c), .zero_out(zo_c));

   rcx_shift_unit #(.N(N), .USE_EXTEND(1'b1)) u_dut_x (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .dst_a(dst_a), .src_b(src_b), .count(count),
      .carry_in(carry_in), .ext_in(ext_in),
      .out_valid(ov_x), .result(res_x), .carry_out(co_x),
      .ext_out(xo_x), .zero_out(zo_x));

   // Step-by-step reference: returns {zero, ext, carry, word}
   function automatic logic [N+2:0] model(input int opi, input logic [N-1:0] a,
         input logic [N-1:0] b, input int cnt, input logic c, input logic x,
         input bit ext);
      logic [N-1:0] r = a;
      logic [N-1:0] sb = b;
      logic f = ext ? x : c;
      logic cf = c;
      logic xf = x;
      logic o = 1'b0;
      logic fb;
      int k;
      if (opi == 2 || opi == 3) begin
         k = cnt % (N + 1);
         for (int i = 0; i < k; i++) begin
            if (opi == 2) begin
               o = r[N-1]; r = {r[N-2:0], f}; f = o;
            end else begin
               o = r[0]; r = {f, r[N-1:1]}; f = o;
            end
         end
      end else begin
         k = cnt % N;
         for (int i = 0; i < k; i++) begin
            if (opi % 2 == 0) begin
               o = r[N-1];
               fb = (opi == 0) ? r[N-1] : (opi == 6) ? sb[N-1] : 1'b0;
               sb = sb << 1;
               r = {r[N-2:0], fb};
            end else begin
               o = r[0];
               fb = (opi == 1) ? r[0] : (opi == 7) ? sb[0] : 1'b0;
               sb = sb >> 1;
               r = {fb, r[N-1:1]};
            end
         end
      end
      if (k != 0) begin
         cf = o;
         if (ext) xf = o;
      end
      return {(r == '0), xf, cf, r};
   endfunction

   task automatic check(input string tag, input logic [N+2:0] act,
         input logic [N+2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual z/x/c/word=%b/%b/%b/%h expected %b/%b/%b/%h",
            tag, act[N+2], act[N+1], act[N], act[N-1:0],
            exp[N+2], exp[N+1], exp[N], exp[N-1:0]);
      end
   endtask

   // issue one operation, then check both variants one edge later
   task automatic run(input string tag, input int opi, input logic [N-1:0] a,
         input logic [N-1:0] b, input int cnt, input logic c, input logic x);
      @(negedge clk);
      in_valid = 1'b1; op = 3'(opi); dst_a = a; src_b = b;
      count = CNT_W'(cnt); carry_in = c; ext_in = x;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, {zo_c, xo_c, co_c, res_c}, model(opi, a, b, cnt, c, x, 1'b0));
      check(tag, {zo_x, xo_x, co_x, res_x}, model(opi, a, b, cnt, c, x, 1'b1));
      checks++;
      if (!(ov_c && ov_x)) begin
         errors++;
         $display("FAIL R11 out_valid actual %b%b expected 11", ov_c, ov_x);
      end
   endtask

   task automatic t_reset();
      checks++;
      if ({ov_c, res_c, co_c, xo_c, zo_c} !== '0 ||
          {ov_x, res_x, co_x, xo_x, zo_x} !== '0) begin
         errors++;
         $display("FAIL R11 reset actual %b %h expected all zero", ov_c, res_c);
      end
   endtask

   task automatic t_rcl_r1();
      for (int k = 1; k <= N; k++) run("R1 rcl", 2, 8'hB5, 8'h00, k, 1'b1, 1'b0);
      run("R1 rcl", 2, 8'h81, 8'h00, 3, 1'b0, 1'b1);
   endtask

   task automatic t_rcr_r2();
      for (int k = 1; k <= N; k++) run("R2 rcr", 3, 8'h4D, 8'h00, k, 1'b0, 1'b1);
      run("R2 rcr", 3, 8'h01, 8'h00, 1, 1'b1, 1'b0);
   endtask

   task automatic t_adc_r3();
      logic [N:0] sum;
      sum = {1'b0, 8'hC3} + {1'b0, 8'hC3} + 9'd1;
      run("R3 rcl1", 2, 8'hC3, 8'h00, 1, 1'b1, 1'b1);
      checks++;
      if ({co_c, res_c} !== sum) begin
         errors++;
         $display("FAIL R3 adc actual %h expected %h", {co_c, res_c}, sum);
      end
   endtask

   task automatic t_mod_r4();
      run("R4 wrap", 2, 8'h5A, 8'h00, N + 1, 1'b1, 1'b0);
      run("R4 wrap", 3, 8'h5A, 8'h00, N + 1, 1'b0, 1'b1);
      run("R4 big",  2, 8'h96, 8'h00, 15, 1'b1, 1'b1);
      run("R4 big",  3, 8'h96, 8'h00, 12, 1'b0, 1'b0);
      run("R4 zero", 3, 8'h33, 8'h00, 0, 1'b1, 1'b0);
   endtask

   task automatic t_rot_r5();
      run("R5 rol", 0, 8'h81, 8'h00, 1, 1'b0, 1'b0);
      run("R5 rol", 0, 8'h3C, 8'h00, 5, 1'b1, 1'b0);
      run("R5 ror", 1, 8'h81, 8'h00, 1, 1'b0, 1'b1);
      run("R5 ror", 1, 8'hA6, 8'h00, 7, 1'b1, 1'b1);
   endtask

   task automatic t_shift_r6();
      run("R6 shl", 4, 8'hFF, 8'h00, 3, 1'b0, 1'b0);
      run("R6 shr", 5, 8'hFF, 8'h00, 7, 1'b1, 1'b0);
      run("R6 shr", 5, 8'h40, 8'h00, 6, 1'b0, 1'b1);
      run("R6 keepflag", 2, 8'h00, 8'h00, 1, 1'b1, 1'b1);
      checks++;
      if (res_c !== 8'h01) begin
         errors++;
         $display("FAIL R6 set flag shifted in actual %h expected 01", res_c);
      end
   endtask

   task automatic t_double_r7();
      run("R7 shld", 6, 8'h12, 8'hE7, 3, 1'b0, 1'b0);
      run("R7 shld", 6, 8'hF0, 8'h0F, 7, 1'b1, 1'b1);
      run("R7 shrd", 7, 8'h12, 8'hE7, 3, 1'b0, 1'b0);
      run("R7 shrd", 7, 8'h0F, 8'hA5, 1, 1'b1, 1'b0);
   endtask

   task automatic t_masked_r8();
      for (int o = 0; o < 8; o++) begin
         if (o == 2 || o == 3) continue;
         run("R8 mask0", o, 8'h6B, 8'h99, N, 1'b1, 1'b0);
         run("R8 cnt0",  o, 8'h6B, 8'h99, 0, 1'b0, 1'b1);
      end
   endtask

   task automatic t_extend_r9();
      run("R9 ext rcl", 2, 8'h80, 8'h00, 1, 1'b1, 1'b0);
      run("R9 ext rcr", 3, 8'h01, 8'h00, 2, 1'b0, 1'b1);
      run("R9 ext shl", 4, 8'h80, 8'h00, 1, 1'b0, 1'b0);
   endtask

   task automatic t_zero_r10();
      run("R10 zero", 4, 8'h01, 8'h00, 1, 1'b0, 1'b0);
      run("R10 zero", 5, 8'h01, 8'h00, 1, 1'b0, 1'b0);
      run("R10 zero", 3, 8'h01, 8'h00, 1, 1'b0, 1'b0);
   endtask

   task automatic t_hold_r11();
      logic [N-1:0] keep;
      run("R11 setup", 0, 8'h5C, 8'h00, 2, 1'b0, 1'b0);
      keep = res_c;
      @(negedge clk);
      op = 3'd4; dst_a = 8'hFF; count = 4'd3; carry_in = 1'b1;
      @(negedge clk);
      checks++;
      if (ov_c || ov_x || res_c !== keep) begin
         errors++;
         $display("FAIL R11 hold actual %b %h expected 0 %h", ov_c, res_c, keep);
      end
   endtask

   initial begin : watchdog
      #(CLK_NS * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_rcl_r1();
      t_rcr_r2();
      t_adc_r3();
      t_mod_r4();
      t_rot_r5();
      t_shift_r6();
      t_double_r7();
      t_masked_r8();
      t_extend_r9();
      t_zero_r10();
      t_hold_r11();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule